// File: doc/BRIEF.md
# Receive Replay Window Checker

This block judges each frame once its security tag has been parsed. For every frame it receives the packet number, the secure-association slot the frame belongs to, the direction, and the parsed tag flags: tag present, authenticate and encrypt. It keeps a record for each association of the next packet number it expects. It raises a one-cycle completion pulse, and a set of status flags stands beside that pulse. The flags are: late against the configured replay window, packet-number exhaustion on transmit, control-only for key agreement, and no tag present.

A received frame that is not late is held as the pending frame. The stored expected number moves forward only when the downstream integrity check reports success for that pending frame. A failed integrity check discards the pending frame and leaves the record as it was.

Top module: `rpw_replay_check`

## Requirements
- R1: After reset, `done` and all four status flags are low, and every slot expects packet number 1.
- R2: `done` is high for exactly one cycle, in the cycle after each cycle with `req_valid` high. All status flags are low whenever `done` is low.
- R3: For a transmit request (`req_tx`=1), `exhausted` is 1 exactly when `req_pn` is greater than `cfg_pn_max`. `late`, `ctrl_only` and `no_tag` stay 0. Transmit requests never become pending and never change any slot.
- R4: For a receive request with `req_has_tag`=0, `no_tag` is 1 and the other flags are 0. The frame does not become pending.
- R5: For a tagged receive request, `late` is 1 exactly when `req_pn` is below the floor. The floor is the slot's expected number minus `cfg_window`, or zero if that difference would be negative. The arithmetic is done at 33 bits.
- R6: For a tagged receive request, `ctrl_only` is 1 exactly when `req_c`=1 and `req_e`=0. Such a frame is still window-checked.
- R7: A tagged receive frame that is not late becomes pending, and it replaces any earlier pending frame. On `auth_valid` with `auth_bad`=0, a pending frame whose number is at or above its slot's expected number sets that expectation to the number plus 1. If the number is below the expectation, the slot is left unchanged. `auth_valid` with nothing pending has no effect.
- R8: `auth_valid` with `auth_bad`=1 leaves every slot unchanged and clears the pending frame.
- R9: When a commit and a new request to the same slot happen in the same cycle, the request is judged against the value after the commit.
- R10: Slots are independent. A commit changes only the pending frame's slot.
- R11: Committing packet number 0xFFFFFFFF sets the expectation to 2^32 with no wrap. With `cfg_window`=0, a later 0xFFFFFFFF is then late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_window | input | 32 | Replay window size |
| cfg_pn_max | input | 32 | Exhaustion threshold for transmit |
| req_valid | input | 1 | A frame is presented this cycle |
| req_tx | input | 1 | 1 = transmit frame, 0 = receive frame |
| req_sa | input | SA_W | Secure-association slot |
| req_pn | input | 32 | Frame packet number |
| req_has_tag | input | 1 | Security tag was found |
| req_c | input | 1 | Authenticate flag from the tag |
| req_e | input | 1 | Encrypt flag from the tag |
| auth_valid | input | 1 | Integrity verdict for the pending frame |
| auth_bad | input | 1 | Integrity check failed |
| done | output | 1 | Completion pulse, gates the flags |
| late | output | 1 | Frame below the replay floor |
| exhausted | output | 1 | Transmit number above threshold |
| ctrl_only | output | 1 | Authenticated but unencrypted frame |
| no_tag | output | 1 | Frame carried no security tag |

## Verification
Two functions can fall in the same cycle: the commit of the pending frame and the window check of a new frame on the same slot. The bench provokes this by asserting `auth_valid` together with `req_valid`. The new packet number is chosen to lie between the old floor and the floor after the commit, so it is late only if the check sees the committed value. A reference model applies the commit first and then the check, and it predicts the flags on every clock. That case, together with slot boundaries, saturation of the floor and the 2^32 expectation, separates a design that forwards the commit from one that does not.

// File: rtl/rpw_pkg.sv
package rpw_pkg;
  localparam int PN_W = 32;

  typedef logic [PN_W:0]   npn_t;
  typedef logic [PN_W-1:0] pn_t;

  typedef struct packed {
    logic late;
    logic exhausted;
    logic ctrl_only;
    logic no_tag;
  } flags_t;

  // lowest acceptable number: expected minus window, clamped at zero
  function automatic npn_t floor_pn(npn_t nxt, pn_t win);
    npn_t w;
    w = {1'b0, win};
    return (nxt > w) ? (nxt - w) : '0;
  endfunction

  function automatic logic below_floor(pn_t pn, npn_t nxt, pn_t win);
    return {1'b0, pn} < floor_pn(nxt, win);
  endfunction

  // expectation after a successful commit of pn
  function automatic npn_t advance(npn_t nxt, pn_t pn);
    return ({1'b0, pn} >= nxt) ? ({1'b0, pn} + npn_t'(1)) : nxt;
  endfunction
endpackage

// File: rtl/rpw_state.sv
module rpw_state
  import rpw_pkg::*;
#(
  parameter int NUM_SA = 8,
  parameter int SA_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SA_W-1:0] rd_sa,
  output npn_t            rd_next,
  input  logic            wr_en,
  input  logic [SA_W-1:0] wr_sa,
  input  npn_t            wr_val,
  output npn_t            wr_old
);
  npn_t slot_q [NUM_SA];

  for (genvar g = 0; g < NUM_SA; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= npn_t'(1);
      else if (wr_en && (wr_sa == SA_W'(g)))
        slot_q[g] <= wr_val;
    end
  end

  assign wr_old = slot_q[wr_sa];
  // forward a same-cycle commit to the checking read
  assign rd_next = (wr_en && (wr_sa == rd_sa)) ? wr_val : slot_q[rd_sa];
endmodule

// File: rtl/rpw_classify.sv
module rpw_classify
  import rpw_pkg::*;
(
  input  logic   req_tx,
  input  logic   req_has_tag,
  input  logic   req_c,
  input  logic   req_e,
  input  pn_t    req_pn,
  input  npn_t   cur_next,
  input  pn_t    cfg_window,
  input  pn_t    cfg_pn_max,
  output flags_t flags,
  output logic   accept
);
  logic rx_tagged;

  always_comb begin
    rx_tagged       = !req_tx && req_has_tag;
    flags           = '0;
    flags.exhausted = req_tx && (req_pn > cfg_pn_max);
    flags.no_tag    = !req_tx && !req_has_tag;
    flags.late      = rx_tagged && below_floor(req_pn, cur_next, cfg_window);
    flags.ctrl_only = rx_tagged && req_c && !req_e;
    accept          = rx_tagged && !flags.late;
  end
endmodule

// File: rtl/rpw_pending.sv
module rpw_pending
  import rpw_pkg::*;
#(
  parameter int SA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            accept,
  input  logic [SA_W-1:0] req_sa,
  input  pn_t             req_pn,
  input  logic            auth_valid,
  input  logic            auth_bad,
  input  npn_t            wr_old,
  output logic            pend_vld,
  output logic            wr_en,
  output logic [SA_W-1:0] wr_sa,
  output npn_t            wr_val
);
  logic            pend_q;
  logic [SA_W-1:0] psa_q;
  pn_t             ppn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      psa_q  <= '0;
      ppn_q  <= '0;
    end else if (req_valid) begin
      pend_q <= accept;
      psa_q  <= req_sa;
      ppn_q  <= req_pn;
    end else if (auth_valid) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_vld = pend_q;
  assign wr_sa    = psa_q;
  assign wr_en    = auth_valid && !auth_bad && pend_q && ({1'b0, ppn_q} >= wr_old);
  assign wr_val   = advance(wr_old, ppn_q);
endmodule

// File: rtl/rpw_replay_check.sv
module rpw_replay_check
  import rpw_pkg::*;
#(
  parameter  int NUM_SA = 8,
  localparam int SA_W   = (NUM_SA > 1) ? $clog2(NUM_SA) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     cfg_window,
  input  logic [31:0]     cfg_pn_max,
  input  logic            req_valid,
  input  logic            req_tx,
  input  logic [SA_W-1:0] req_sa,
  input  logic [31:0]     req_pn,
  input  logic            req_has_tag,
  input  logic            req_c,
  input  logic            req_e,
  input  logic            auth_valid,
  input  logic            auth_bad,
  output logic            done,
  output logic            late,
  output logic            exhausted,
  output logic            ctrl_only,
  output logic            no_tag
);
  npn_t            cur_next;
  npn_t            wr_old;
  npn_t            wr_val;
  logic            wr_en;
  logic [SA_W-1:0] wr_sa;
  logic            pend_vld;
  logic            accept;
  flags_t          flags_c;
  flags_t          flags_q;
  logic            done_q;

  rpw_state #(.NUM_SA(NUM_SA), .SA_W(SA_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .rd_sa(req_sa), .rd_next(cur_next),
    .wr_en(wr_en), .wr_sa(wr_sa), .wr_val(wr_val), .wr_old(wr_old)
  );

  rpw_classify u_classify (
    .req_tx(req_tx), .req_has_tag(req_has_tag), .req_c(req_c), .req_e(req_e),
    .req_pn(req_pn), .cur_next(cur_next),
    .cfg_window(cfg_window), .cfg_pn_max(cfg_pn_max),
    .flags(flags_c), .accept(accept)
  );

  rpw_pending #(.SA_W(SA_W)) u_pending (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .accept(accept), .req_sa(req_sa), .req_pn(req_pn),
    .auth_valid(auth_valid), .auth_bad(auth_bad), .wr_old(wr_old),
    .pend_vld(pend_vld), .wr_en(wr_en), .wr_sa(wr_sa), .wr_val(wr_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      flags_q <= '0;
    end else begin
      done_q  <= req_valid;
      flags_q <= req_valid ? flags_c : '0;
    end
  end

  assign done      = done_q;
  assign late      = flags_q.late;
  assign exhausted = flags_q.exhausted;
  assign ctrl_only = flags_q.ctrl_only;
  assign no_tag    = flags_q.no_tag;
endmodule

// File: rtl/rpw_checker.sv
module rpw_checker
  import rpw_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_tx,
  input logic auth_valid,
  input logic auth_bad,
  input logic done,
  input logic late,
  input logic exhausted,
  input logic ctrl_only,
  input logic no_tag,
  input logic wr_en,
  input logic pend_vld,
  input npn_t wr_val,
  input npn_t wr_old
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done) else $error("done missing"); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done) else $error("stray done"); // R2
  AST_FLAGS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(late || exhausted || ctrl_only || no_tag)) else $error("ungated flag"); // R2
  AST_TX_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_tx) |=> !(late || ctrl_only || no_tag)) else $error("tx flag"); // R3
  AST_RX_NO_EXH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_tx) |=> !exhausted) else $error("rx exhaust"); // R3
  AST_NOTAG_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    no_tag |-> !(late || ctrl_only || exhausted)) else $error("no_tag mix"); // R4
  AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (auth_valid && auth_bad) |-> !wr_en) else $error("bad commit"); // R8
  AST_WRITE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (pend_vld && auth_valid)) else $error("commit w/o pending"); // R7
  AST_WRITE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_val > wr_old)) else $error("non-advancing commit"); // R7
endmodule

bind rpw_replay_check rpw_checker u_rpw_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tx(req_tx),
  .auth_valid(auth_valid), .auth_bad(auth_bad), .done(done), .late(late),
  .exhausted(exhausted), .ctrl_only(ctrl_only), .no_tag(no_tag),
  .wr_en(wr_en), .pend_vld(pend_vld), .wr_val(wr_val), .wr_old(wr_old)
);

// File: tb/rpw_replay_check_tb_top.sv
module rpw_replay_check_tb_top;
  localparam int NSA = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_window = 32'd4;
  logic [31:0] cfg_pn_max = 32'd100;
  logic        req_valid = 1'b0, req_tx = 1'b0, req_has_tag = 1'b0, req_c = 1'b0, req_e = 1'b0;
  logic [2:0]  req_sa = '0;
  logic [31:0] req_pn = '0;
  logic        auth_valid = 1'b0, auth_bad = 1'b0;
  logic        done, late, exhausted, ctrl_only, no_tag;

  always #5 clk = ~clk;

  rpw_replay_check #(.NUM_SA(NSA)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_window(cfg_window), .cfg_pn_max(cfg_pn_max),
    .req_valid(req_valid), .req_tx(req_tx), .req_sa(req_sa), .req_pn(req_pn),
    .req_has_tag(req_has_tag), .req_c(req_c), .req_e(req_e),
    .auth_valid(auth_valid), .auth_bad(auth_bad),
    .done(done), .late(late), .exhausted(exhausted), .ctrl_only(ctrl_only), .no_tag(no_tag)
  );

  int      n_checks = 0;
  int      n_errors = 0;
  longint  expect_nxt [NSA];
  bit      m_pend = 0;
  int      m_psa = 0;
  longint  m_ppn = 0;
  logic [4:0] exp_vec = '0;
  string   exp_req = "R1";
  bit      finished = 0;

  task automatic compare();
    logic [4:0] act;
    act = {done, late, exhausted, ctrl_only, no_tag};
    n_checks++;
    if (act !== exp_vec) begin
      n_errors++;
      $display("FAIL %s {done,late,exh,ctrl,notag} actual=%b expected=%b", exp_req, act, exp_vec);
    end
  endtask

  // one clock: check last result, drive, advance the model, wait
  task automatic cyc(bit rv, bit tx, bit tg, bit c, bit e, int sa, longint pn,
                     bit av, bit ab, string tag_s);
    longint flo;
    bit l, x, k, n;
    compare();
    req_valid = rv; req_tx = tx; req_has_tag = tg; req_c = c; req_e = e;
    req_sa = 3'(sa); req_pn = 32'(pn); auth_valid = av; auth_bad = ab;
    if (av) begin
      if (m_pend && !ab && (m_ppn >= expect_nxt[m_psa])) expect_nxt[m_psa] = m_ppn + 1;
      m_pend = 0;
    end
    l = 0; x = 0; k = 0; n = 0;
    if (rv) begin
      if (tx) x = (pn > longint'(cfg_window) * 0 + longint'(cfg_pn_max));
      else if (!tg) n = 1;
      else begin
        flo = (expect_nxt[sa] > longint'(cfg_window)) ? expect_nxt[sa] - longint'(cfg_window) : 0;
        l = (pn < flo);
        k = c && !e;
      end
      m_pend = !tx && tg && !l;
      m_psa = sa;
      m_ppn = pn;
    end
    exp_vec = {rv, l, x, k, n};
    exp_req = tag_s;
    @(negedge clk);
  endtask

  task automatic idle(string tag_s);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag_s);
  endtask

  task automatic rx(int sa, longint pn, string tag_s);
    cyc(1, 0, 1, 1, 1, sa, pn, 0, 0, tag_s);
  endtask

  task automatic commit(bit bad, string tag_s);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, bad, tag_s);
  endtask

  initial begin
    for (int i = 0; i < NSA; i++) expect_nxt[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1");                         // checks reset state
    idle("R1");
    // basic window, sa0 expects 1, window 4
    rx(0, 1, "R5");
    commit(0, "R7");                    // expectation 2
    rx(0, 20, "R5");
    commit(0, "R7");                    // expectation 21, floor 17
    rx(0, 17, "R5");
    rx(0, 16, "R5");                    // late
    // failed integrity leaves state
    rx(0, 50, "R8");
    commit(1, "R8");
    rx(0, 16, "R8");                    // still late
    rx(0, 17, "R8");
    // commit below expectation: unchanged
    rx(0, 30, "R7");
    commit(0, "R7");                    // expectation 31, floor 27
    rx(0, 28, "R7");
    commit(0, "R7");                    // 28 < 31: no change
    rx(0, 26, "R7");                    // late
    rx(0, 27, "R7");
    // auth with nothing pending
    commit(0, "R7");
    commit(0, "R7");
    rx(0, 26, "R7");
    // no tag, ctrl-only
    cyc(1, 0, 0, 1, 1, 0, 5, 0, 0, "R4");
    commit(0, "R4");                    // no-tag never pending
    rx(0, 26, "R4");
    cyc(1, 0, 1, 1, 0, 0, 40, 0, 0, "R6");
    cyc(1, 0, 1, 0, 0, 0, 40, 0, 0, "R6");
    cyc(1, 0, 1, 1, 0, 0, 3, 0, 0, "R6"); // ctrl-only and late
    // transmit exhaustion
    cyc(1, 1, 1, 1, 1, 0, 100, 0, 0, "R3");
    cyc(1, 1, 1, 1, 1, 0, 101, 0, 0, "R3");
    cyc(1, 1, 0, 1, 0, 0, 0, 0, 0, "R3");
    commit(0, "R3");                    // tx never pending
    rx(0, 26, "R3");
    // slot independence
    rx(3, 0, "R10");
    rx(3, 1, "R10");
    commit(0, "R10");                   // sa3 expects 2
    rx(0, 27, "R10");
    rx(0, 26, "R10");
    // same-cycle commit and check
    rx(0, 60, "R9");
    cyc(1, 0, 1, 1, 1, 0, 56, 1, 0, "R9");  // floor jumps to 57: late
    rx(0, 57, "R9");
    rx(0, 70, "R9");
    cyc(1, 0, 1, 1, 1, 0, 67, 1, 1, "R9");  // bad commit: floor stays 57
    // top of the number space
    rx(1, 64'hFFFF_FFFF, "R11");
    commit(0, "R11");
    cfg_window = 32'd0;
    rx(1, 64'hFFFF_FFFF, "R11");        // late against 2^32
    rx(2, 1, "R11");
    cfg_window = 32'hFFFF_FFFF;
    rx(2, 0, "R5");                     // floor saturates at zero
    cfg_pn_max = 32'hFFFF_FFFF;
    cyc(1, 1, 1, 1, 1, 0, 64'hFFFF_FFFF, 0, 0, "R3");
    idle("R2");
    idle("R2");
    compare();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule